// File: doc/BRIEF.md
# Copper PHY Management Register File

This block holds the management registers of a gigabit copper PHY. A host reaches it over a simple parallel bus: a 5-bit register address, 16-bit write data, a write strobe and a read strobe. Status arrives live from the PHY core: link up, remote fault, jabber, page received, negotiation done and the resolved master/slave role. Three kinds of error event arrive as one-cycle pulses: receive errors, idle errors and failed master/slave resolutions. The block drives control fields back to the core. These are a software reset pulse, a negotiation restart pulse, loopback, isolate, power-down, the speed and duplex selections, and the advertisement and master/slave control words.

Each bit follows its own access rule. A bit may be read-only, read/write, self-clearing, latch-high or latch-low. Status bits latch the events they report, so that software reading the register later still sees them. Error tallies stop at all ones rather than wrapping, and they clear when software reads them. A software reset reloads the control register. The advertisement and master/slave control registers keep what software last wrote.

Read data is captured on the clock edge that samples the read strobe and is presented from the following cycle. Any side effect of that read, such as re-arming a latch or clearing a tally, takes effect on the same edge.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the control register (address 0) reads 0x1140: negotiation enable (bit 12) = 1, full duplex (bit 8) = 1, speed bits 6/13 = 1/0 (ctl_speed_sel = 2'b10, 1000 Mb/s), and every other bit 0.
- R2: Writing 1 to control bit 15 drives ctl_sw_reset high for exactly the cycle after the write. On the following edge the control register reloads 0x1140 and bit 15 reads back 0.
- R3: Writing 1 to control bit 9 drives ctl_an_restart high for exactly one cycle, after which bit 9 reads 0. The other control bits keep the written value.
- R4: The advertisement register (address 4) resets to 0x01E1 and the master/slave control register (address 9) to 0x0F00 (with 10/100 advertisement on). A software reset leaves both unchanged.
- R5: Only these bits take writes: control bits 15:6, advertisement bits 13, 11:10 and 8:5, and master/slave control bits 12:8. All other bits read 0, except advertisement bits 4:0, which always read 00001.
- R6: Status (address 1) bit 2 is latch-low. Once lnk_up is seen low, the bit reads 0 until status is read; after that read it follows lnk_up again. It resets to 0.
- R7: Status bit 4 (remote fault), status bit 1 (jabber) and expansion (address 6) bit 1 (page received) are latch-high. Each one stays 1 until its register is read, and after the read it clears unless its input is still high.
- R8: Status bits 8, 6, 3 and 0 always read 1. Status bit 5 follows an_done. Expansion bit 2 always reads 1.
- R9: Master/slave status (address 10) bit 15 sets on the 7th counted resolution failure. A read of address 10 clears both this bit and the failure tally. Bit 14 follows ms_is_master.
- R10: Master/slave status bits 7:0 count idle_err_evt pulses. The count stops at 0xFF and clears when address 10 is read; an event in the same cycle as that read leaves the count at 1.
- R11: Address 21 counts rx_err_evt pulses in 16 bits. The count stops at 0xFFFF and clears when address 21 is read.
- R12: Unimplemented addresses read 0. Writes to them and to addresses 1, 6, 10 and 21 change nothing.
- R13: bus_rdata takes the addressed value on the edge where bus_re is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| lnk_up | input | 1 | Live link state |
| rmt_fault | input | 1 | Live remote fault |
| jabber | input | 1 | Live jabber condition |
| page_rx | input | 1 | Page received event |
| an_done | input | 1 | Negotiation complete |
| ms_is_master | input | 1 | Resolved master role |
| rx_err_evt | input | 1 | Receive error pulse |
| idle_err_evt | input | 1 | Idle error pulse |
| ms_fail_evt | input | 1 | Failed master/slave resolution pulse |
| ctl_sw_reset | output | 1 | Software reset pulse |
| ctl_an_restart | output | 1 | Negotiation restart pulse |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_power_down | output | 1 | Power-down |
| ctl_isolate | output | 1 | Isolate |
| ctl_an_enable | output | 1 | Negotiation enable |
| ctl_full_duplex | output | 1 | Full duplex select |
| ctl_speed_sel | output | 2 | Speed select {bit 6, bit 13} |
| ctl_col_test | output | 1 | Collision test enable |
| adv_word | output | 16 | Advertisement register contents |
| ms_ctl_word | output | 16 | Master/slave control register contents |

## Verification
The checks assume that bus_we and bus_re are never high in the same cycle and that the event inputs are single-cycle pulses sampled on the clock. Under that assumption a read's side effects and a write's effects never overlap. The bench never raises both strobes together. It issues each event by holding the input high for whole cycles, so a held input counts once per cycle, which the saturation tests use on purpose. In the random phase, writes to bit 15 of the control register are masked off, so a software reset never occurs there. Software reset is exercised only in the directed sequence.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam logic [4:0] A_CTRL   = 5'd0;
  localparam logic [4:0] A_STAT   = 5'd1;
  localparam logic [4:0] A_ADV    = 5'd4;
  localparam logic [4:0] A_EXP    = 5'd6;
  localparam logic [4:0] A_MSCTL  = 5'd9;
  localparam logic [4:0] A_MSSTAT = 5'd10;
  localparam logic [4:0] A_RXERR  = 5'd21;

  localparam logic [15:0] CTRL_INIT  = 16'h1140;
  localparam logic [15:0] CTRL_WMASK = 16'hFFC0;
  localparam logic [15:0] STAT_ONES  = 16'h0149;
  localparam logic [15:0] ADV_WMASK  = 16'h2DE0;
  localparam logic [15:0] ADV_SEL    = 16'h0001;
  localparam logic [15:0] MS_WMASK   = 16'h1F00;
  localparam logic [15:0] EXP_ONES   = 16'h0004;

  // Next state of a sticky status bit: a read re-arms it from the live input.
  function automatic logic latch_next(input bit hold_high, input logic cur,
                                      input logic live, input logic rd);
    if (rd) return live;
    return hold_high ? (cur | live) : (cur & live);
  endfunction

  function automatic logic [15:0] adv_init(input bit legacy);
    return (legacy ? 16'h01E0 : 16'h0000) | ADV_SEL;
  endfunction

  function automatic logic [15:0] ms_init(input bit legacy);
    return 16'h0E00 | (legacy ? 16'h0100 : 16'h0000);
  endfunction

endpackage

// File: rtl/mgmt_latch_bit.sv
module mgmt_latch_bit #(
  parameter bit HOLD_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic rd_clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= phy_mgmt_pkg::latch_next(HOLD_HIGH, q, live, rd_clr);
  end
endmodule

// File: rtl/mgmt_sat_counter.sv
module mgmt_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] c, input logic i);
    return (i && c != TOP) ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= sat_step(clr ? '0 : count, inc);
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int RXERR_W       = 16,
  parameter int IDLE_W        = 8,
  parameter int MS_FAIL_LIMIT = 7,
  parameter bit ADV_LEGACY    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [15:0] bus_rdata,
  input  logic        lnk_up,
  input  logic        rmt_fault,
  input  logic        jabber,
  input  logic        page_rx,
  input  logic        an_done,
  input  logic        ms_is_master,
  input  logic        rx_err_evt,
  input  logic        idle_err_evt,
  input  logic        ms_fail_evt,
  output logic        ctl_sw_reset,
  output logic        ctl_an_restart,
  output logic        ctl_loopback,
  output logic        ctl_power_down,
  output logic        ctl_isolate,
  output logic        ctl_an_enable,
  output logic        ctl_full_duplex,
  output logic [1:0]  ctl_speed_sel,
  output logic        ctl_col_test,
  output logic [15:0] adv_word,
  output logic [15:0] ms_ctl_word
);
  localparam int TALLY_W = $clog2(MS_FAIL_LIMIT + 1);
  localparam int NLAT = 5;
  // index: 0 link (latch-low), 1 remote fault, 2 jabber, 3 page, 4 ms fault
  localparam logic [NLAT-1:0] LAT_HIGH = 5'b11110;

  // Named bus events
  logic wr_ctrl, wr_adv, wr_ms;
  logic rd_stat, rd_exp, rd_msstat, rd_rxerr;
  assign wr_ctrl   = bus_we && bus_addr == A_CTRL;
  assign wr_adv    = bus_we && bus_addr == A_ADV;
  assign wr_ms     = bus_we && bus_addr == A_MSCTL;
  assign rd_stat   = bus_re && bus_addr == A_STAT;
  assign rd_exp    = bus_re && bus_addr == A_EXP;
  assign rd_msstat = bus_re && bus_addr == A_MSSTAT;
  assign rd_rxerr  = bus_re && bus_addr == A_RXERR;

  // Control register with self-clearing bits 15 and 9
  logic [15:0] ctrl_q;
  logic        sw_reset_fire, an_restart_fire;
  assign sw_reset_fire   = ctrl_q[15];
  assign an_restart_fire = ctrl_q[9];

  always_ff @(posedge clk) begin
    if (!rst_n)             ctrl_q <= CTRL_INIT;
    else if (sw_reset_fire) ctrl_q <= CTRL_INIT;
    else if (wr_ctrl)       ctrl_q <= bus_wdata & CTRL_WMASK;
    else                    ctrl_q[9] <= 1'b0;
  end

  // Retained registers: untouched by software reset
  logic [15:0] adv_q, ms_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_q <= adv_init(ADV_LEGACY);
      ms_q  <= ms_init(ADV_LEGACY);
    end else begin
      if (wr_adv) adv_q <= (bus_wdata & ADV_WMASK) | ADV_SEL;
      if (wr_ms)  ms_q  <= bus_wdata & MS_WMASK;
    end
  end

  // Master/slave failure tally
  logic [TALLY_W-1:0] ms_tally;
  logic               ms_fault_set;
  assign ms_fault_set = ms_fail_evt && (ms_tally == TALLY_W'(MS_FAIL_LIMIT - 1));

  mgmt_sat_counter #(.W(TALLY_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .inc(ms_fail_evt), .clr(rd_msstat), .count(ms_tally));

  // Sticky status bits
  logic [NLAT-1:0] lat_live, lat_rd, lat_q;
  assign lat_live = {ms_fault_set, page_rx, jabber, rmt_fault, lnk_up};
  assign lat_rd   = {rd_msstat, rd_exp, rd_stat, rd_stat, rd_stat};

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    mgmt_latch_bit #(.HOLD_HIGH(LAT_HIGH[i])) u_lat (
      .clk(clk), .rst_n(rst_n), .live(lat_live[i]), .rd_clr(lat_rd[i]), .q(lat_q[i]));
  end

  // Error tallies
  logic [IDLE_W-1:0]  idle_cnt;
  logic [RXERR_W-1:0] rxerr_cnt;

  mgmt_sat_counter #(.W(IDLE_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .inc(idle_err_evt), .clr(rd_msstat), .count(idle_cnt));
  mgmt_sat_counter #(.W(RXERR_W)) u_rxerr (
    .clk(clk), .rst_n(rst_n), .inc(rx_err_evt), .clr(rd_rxerr), .count(rxerr_cnt));

  // Read mux
  logic [15:0] rd_value;
  logic [7:0]  idle8;
  logic [15:0] rx16;
  assign idle8 = 8'(idle_cnt);
  assign rx16  = 16'(rxerr_cnt);

  always_comb begin
    case (bus_addr)
      A_CTRL:   rd_value = ctrl_q;
      A_STAT:   rd_value = STAT_ONES | {10'd0, an_done, lat_q[1], 1'b0, lat_q[0], lat_q[2], 1'b0};
      A_ADV:    rd_value = adv_q;
      A_EXP:    rd_value = EXP_ONES | {14'd0, lat_q[3], 1'b0};
      A_MSCTL:  rd_value = ms_q;
      A_MSSTAT: rd_value = {lat_q[4], ms_is_master, 6'd0, idle8};
      A_RXERR:  rd_value = rx16;
      default:  rd_value = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 16'h0000;
    else if (bus_re) bus_rdata <= rd_value;
  end

  // Control outputs
  assign ctl_sw_reset    = sw_reset_fire;
  assign ctl_an_restart  = an_restart_fire;
  assign ctl_loopback    = ctrl_q[14];
  assign ctl_an_enable   = ctrl_q[12];
  assign ctl_power_down  = ctrl_q[11];
  assign ctl_isolate     = ctrl_q[10];
  assign ctl_full_duplex = ctrl_q[8];
  assign ctl_col_test    = ctrl_q[7];
  assign ctl_speed_sel   = {ctrl_q[6], ctrl_q[13]};
  assign adv_word        = adv_q;
  assign ms_ctl_word     = ms_q;
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int RXERR_W = 16,
  parameter int IDLE_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4:0]         bus_addr,
  input logic [15:0]        bus_wdata,
  input logic               bus_we,
  input logic               bus_re,
  input logic [15:0]        bus_rdata,
  input logic               ctl_sw_reset,
  input logic               ctl_an_restart,
  input logic               ctl_an_enable,
  input logic               ctl_full_duplex,
  input logic [1:0]         ctl_speed_sel,
  input logic               ctl_loopback,
  input logic               idle_err_evt,
  input logic               link_lat,
  input logic               jab_lat,
  input logic               ms_fault,
  input logic               rd_stat,
  input logic               rd_msstat,
  input logic               rd_rxerr,
  input logic [IDLE_W-1:0]  idle_cnt,
  input logic [RXERR_W-1:0] rxerr_cnt
);
  logic addr_known;
  assign addr_known = bus_addr inside {5'd0, 5'd1, 5'd4, 5'd6, 5'd9, 5'd10, 5'd21};

  AST_SWRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sw_reset |=> !ctl_sw_reset); // R2
  AST_SWRST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sw_reset |=> (ctl_an_enable && ctl_full_duplex && ctl_speed_sel == 2'b10 && !ctl_loopback)); // R2
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_an_restart && !(bus_we && bus_addr == 5'd0 && bus_wdata[9])) |=> !ctl_an_restart); // R3
  AST_LINK_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_lat && !rd_stat) |=> !link_lat); // R6
  AST_JABBER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_lat && !rd_stat) |=> jab_lat); // R7
  AST_MSFAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_fault && !rd_msstat) |=> ms_fault); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msstat && !idle_err_evt) |=> idle_cnt == '0); // R10
  AST_RXERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rxerr_cnt == '1 && !rd_rxerr) |=> rxerr_cnt == '1); // R11
  AST_RXERR_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rxerr |=> rxerr_cnt >= $past(rxerr_cnt)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !addr_known) |=> bus_rdata == 16'h0000); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata)); // R13
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.RXERR_W(RXERR_W), .IDLE_W(IDLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .ctl_sw_reset(ctl_sw_reset), .ctl_an_restart(ctl_an_restart),
  .ctl_an_enable(ctl_an_enable), .ctl_full_duplex(ctl_full_duplex),
  .ctl_speed_sel(ctl_speed_sel), .ctl_loopback(ctl_loopback),
  .idle_err_evt(idle_err_evt), .link_lat(lat_q[0]), .jab_lat(lat_q[2]),
  .ms_fault(lat_q[4]), .rd_stat(rd_stat), .rd_msstat(rd_msstat),
  .rd_rxerr(rd_rxerr), .idle_cnt(idle_cnt), .rxerr_cnt(rxerr_cnt));

// File: tb/sim_phy_mgmt_regs.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic lnk_up = 0, rmt_fault = 0, jabber = 0, page_rx = 0, an_done = 0, ms_is_master = 0;
  logic rx_err_evt = 0, idle_err_evt = 0, ms_fail_evt = 0;
  logic ctl_sw_reset, ctl_an_restart, ctl_loopback, ctl_power_down, ctl_isolate;
  logic ctl_an_enable, ctl_full_duplex, ctl_col_test;
  logic [1:0]  ctl_speed_sel;
  logic [15:0] adv_word, ms_ctl_word;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_mgmt_regs u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic pulse(ref logic sig, input int n);
    @(negedge clk); sig = 1;
    repeat (n) @(negedge clk);
    sig = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    {rmt_fault, jabber, page_rx, an_done, ms_is_master, rx_err_evt, idle_err_evt, ms_fail_evt} = '0;
    bus_we = 0; bus_re = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; lnk_up = 1;
  endtask

  // Reference state for the random phase
  logic [15:0] m_ctrl, m_adv, m_ms, m_rxe;
  logic [7:0]  m_idle;
  logic [2:0]  m_tally;
  logic m_link, m_rf, m_jab, m_pg, m_fault;

  function automatic logic [15:0] exp_read(input logic [4:0] a);
    case (a)
      5'd0:  return m_ctrl;
      5'd1:  return 16'h0149 | (16'(an_done) << 5) | (16'(m_rf) << 4) | (16'(m_link) << 2) | (16'(m_jab) << 1);
      5'd4:  return m_adv;
      5'd6:  return 16'h0004 | (16'(m_pg) << 1);
      5'd9:  return m_ms;
      5'd10: return {m_fault, ms_is_master, 6'd0, m_idle};
      5'd21: return m_rxe;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] a);
    case (a)
      5'd0: return "R3"; 5'd1: return "R6"; 5'd4: return "R5"; 5'd6: return "R7";
      5'd9: return "R5"; 5'd10: return "R10"; 5'd21: return "R11";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [4:0]  raddrs[8];
    logic [4:0]  waddrs[8];
    bit          pend;
    logic [15:0] pend_val;
    string       pend_req;
    int          seed;
    seed = $urandom(32'd20240611);
    raddrs = '{5'd0, 5'd1, 5'd4, 5'd6, 5'd9, 5'd10, 5'd21, 5'd3};
    waddrs = '{5'd0, 5'd4, 5'd9, 5'd1, 5'd10, 5'd21, 5'd6, 5'd17};

    do_reset();
    // R1 reset state
    @(negedge clk);
    chk("R1 an_enable", 16'(ctl_an_enable), 16'd1);
    chk("R1 full_duplex", 16'(ctl_full_duplex), 16'd1);
    chk("R1 speed", 16'(ctl_speed_sel), 16'd2);
    chk("R1 sw_reset idle", 16'(ctl_sw_reset), 16'd0);
    rd(5'd0, d); chk("R1 ctrl reads", d, 16'h1140);
    rd(5'd4, d); chk("R4 adv default", d, 16'h01E1);
    rd(5'd9, d); chk("R4 msctl default", d, 16'h0F00);
    rd(5'd1, d); chk("R6 link latched low after reset", d, 16'h0149);
    rd(5'd1, d); chk("R6 link follows live after read", d, 16'h014D);
    rd(5'd6, d); chk("R8 expansion constant", d, 16'h0004);
    an_done = 1;
    rd(5'd1, d); chk("R8 an_done live", d, 16'h016D);
    an_done = 0;

    // R5 write masks
    wr(5'd4, 16'hFFFF); rd(5'd4, d); chk("R5 adv mask, selector", d, 16'h2DE1);
    wr(5'd4, 16'h0000); rd(5'd4, d); chk("R5 selector read-only", d, 16'h0001);
    wr(5'd4, 16'hFFFF);
    wr(5'd9, 16'hFFFF); rd(5'd9, d); chk("R5 msctl mask", d, 16'h1F00);
    wr(5'd0, 16'h5D3F); rd(5'd0, d); chk("R5 ctrl low bits zero", d, 16'h5D00);
    chk("R5 loopback out", 16'(ctl_loopback), 16'd1);
    chk("R5 power_down out", 16'(ctl_power_down), 16'd1);
    chk("R5 speed out", 16'(ctl_speed_sel), 16'd0);

    // R3 restart pulse
    wr(5'd0, 16'h1340);
    chk("R3 restart high", 16'(ctl_an_restart), 16'd1);
    @(negedge clk);
    chk("R3 restart one cycle", 16'(ctl_an_restart), 16'd0);
    rd(5'd0, d); chk("R3 bit9 clears, others kept", d, 16'h1140);

    // R2 software reset, R4 retain
    wr(5'd0, 16'h4C80);
    wr(5'd0, 16'hC000);
    chk("R2 sw_reset high", 16'(ctl_sw_reset), 16'd1);
    @(negedge clk);
    chk("R2 sw_reset one cycle", 16'(ctl_sw_reset), 16'd0);
    chk("R2 loopback reloaded", 16'(ctl_loopback), 16'd0);
    rd(5'd0, d); chk("R2 ctrl reloaded", d, 16'h1140);
    rd(5'd4, d); chk("R4 adv retained", d, 16'h2DE1);
    rd(5'd9, d); chk("R4 msctl retained", d, 16'h1F00);

    // R12 unmapped and read-only addresses
    wr(5'd3, 16'hFFFF); rd(5'd3, d); chk("R12 unmapped read", d, 16'h0000);
    rd(5'd31, d); chk("R12 unmapped 31", d, 16'h0000);
    wr(5'd1, 16'hFFFF); rd(5'd1, d); chk("R12 status write ignored", d, 16'h014D);
    wr(5'd21, 16'hFFFF); rd(5'd21, d); chk("R12 counter write ignored", d, 16'h0000);

    // R7 latch-high bits
    pulse(rmt_fault, 1);
    rd(5'd1, d); chk("R7 remote fault latched", d, 16'h015D);
    rd(5'd1, d); chk("R7 remote fault cleared", d, 16'h014D);
    @(negedge clk); jabber = 1;
    rd(5'd1, d); chk("R7 jabber latched", d, 16'h014F);
    rd(5'd1, d); chk("R7 jabber held while live", d, 16'h014F);
    jabber = 0;
    rd(5'd1, d); chk("R7 jabber re-latched by read", d, 16'h014F);
    rd(5'd1, d); chk("R7 jabber clear", d, 16'h014D);
    pulse(page_rx, 1);
    rd(5'd6, d); chk("R7 page latched", d, 16'h0006);
    rd(5'd6, d); chk("R7 page cleared", d, 16'h0004);
    // R6 latch-low
    pulse(lnk_up, 0);
    @(negedge clk); lnk_up = 0; @(negedge clk); lnk_up = 1;
    repeat (2) @(negedge clk);
    rd(5'd1, d); chk("R6 link drop held", d, 16'h0149);
    rd(5'd1, d); chk("R6 link restored", d, 16'h014D);

    // R9 master/slave fault
    repeat (6) pulse(ms_fail_evt, 1);
    rd(5'd10, d); chk("R9 six failures no fault", d, 16'h0000);
    repeat (6) pulse(ms_fail_evt, 1);
    rd(5'd10, d); chk("R9 tally cleared by read", d, 16'h0000);
    repeat (7) pulse(ms_fail_evt, 1);
    ms_is_master = 1;
    rd(5'd10, d); chk("R9 seventh failure sets fault", d, 16'hC000);
    ms_is_master = 0;
    rd(5'd10, d); chk("R9 fault cleared by read", d, 16'h0000);

    // R10 idle count saturation
    pulse(idle_err_evt, 300);
    rd(5'd10, d); chk("R10 idle saturates", d, 16'h00FF);
    rd(5'd10, d); chk("R10 idle cleared", d, 16'h0000);
    pulse(idle_err_evt, 3);
    @(negedge clk); idle_err_evt = 1; bus_addr = 5'd10; bus_re = 1;
    @(negedge clk); idle_err_evt = 0; bus_re = 0;
    chk("R10 read before coincident event", bus_rdata, 16'h0003);
    rd(5'd10, d); chk("R10 coincident event counted", d, 16'h0001);

    // R11 receive error counter
    pulse(rx_err_evt, 5);
    rd(5'd21, d); chk("R11 rx count", d, 16'h0005);
    pulse(rx_err_evt, 65600);
    rd(5'd21, d); chk("R11 rx saturates", d, 16'hFFFF);
    rd(5'd21, d); chk("R11 rx cleared", d, 16'h0000);

    // R13 read data holds
    rd(5'd9, d);
    wr(5'd9, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R13 rdata held", bus_rdata, 16'h1F00);
    rd(5'd9, d); chk("R13 new read", d, 16'h0000);

    // Random phase against reference state
    do_reset();
    m_ctrl = 16'h1140; m_adv = 16'h01E1; m_ms = 16'h0F00;
    m_rxe = '0; m_idle = '0; m_tally = '0;
    {m_link, m_rf, m_jab, m_pg, m_fault} = '0;
    pend = 0; pend_val = '0; pend_req = "";
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [4:0] a;
      logic [15:0] w;
      bit r0, r1, r6, r10, r21, fset;
      @(negedge clk);
      if (pend) chk(pend_req, bus_rdata, pend_val);
      op = $urandom_range(0, 9);
      a = (op < 4) ? raddrs[$urandom_range(0, 7)] : waddrs[$urandom_range(0, 7)];
      if ($urandom_range(0, 7) == 0) a = 5'($urandom);
      w = 16'($urandom);
      if (a == 5'd0) w[15] = 1'b0;
      bus_addr = a; bus_wdata = w;
      bus_re = (op < 4); bus_we = (op == 4 || op == 5);
      lnk_up = ($urandom_range(0, 9) != 0);
      rmt_fault = ($urandom_range(0, 15) == 0);
      jabber = ($urandom_range(0, 15) == 0);
      page_rx = ($urandom_range(0, 7) == 0);
      an_done = 1'($urandom);
      ms_is_master = 1'($urandom);
      rx_err_evt = ($urandom_range(0, 3) == 0);
      idle_err_evt = ($urandom_range(0, 3) == 0);
      ms_fail_evt = ($urandom_range(0, 5) == 0);
      pend = bus_re;
      if (pend) begin pend_val = exp_read(a); pend_req = req_of(a); end
      r0 = 0;
      r1 = bus_re && a == 5'd1; r6 = bus_re && a == 5'd6;
      r10 = bus_re && a == 5'd10; r21 = bus_re && a == 5'd21;
      m_link = r1 ? lnk_up : (m_link & lnk_up);
      m_rf   = r1 ? rmt_fault : (m_rf | rmt_fault);
      m_jab  = r1 ? jabber : (m_jab | jabber);
      m_pg   = r6 ? page_rx : (m_pg | page_rx);
      fset = ms_fail_evt && m_tally == 3'd6;
      m_fault = r10 ? fset : (m_fault | fset);
      if (r10) m_tally = 0;
      if (ms_fail_evt && m_tally != 3'd7) m_tally++;
      if (r10) m_idle = 0;
      if (idle_err_evt && m_idle != 8'hFF) m_idle++;
      if (r21) m_rxe = 0;
      if (rx_err_evt && m_rxe != 16'hFFFF) m_rxe++;
      r0 = bus_we && a == 5'd0;
      if (r0) m_ctrl = w & 16'hFFC0;
      else m_ctrl[9] = 1'b0;
      if (bus_we && a == 5'd4) m_adv = (w & 16'h2DE0) | 16'h0001;
      if (bus_we && a == 5'd9) m_ms = w & 16'h1F00;
    end
    @(negedge clk);
    if (pend) chk(pend_req, bus_rdata, pend_val);
    bus_re = 0; bus_we = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule